// File: doc/BRIEF.md
# I2C ADC result readout slave

This block is the target-side protocol engine of a four-channel, 12-bit sampling converter on an I2C bus. It watches the open-drain SCL and SDA lines, recognises its own 7-bit address followed by a read bit, and acknowledges by pulling SDA low. It then streams two-byte result words for as long as the controller acknowledges each second byte. A NACK on any data byte ends the stream.

Each word is sent MSB first. It holds two zero bits, a 2-bit channel identifier and the 12-bit result. A conversion is started at the ninth SCL rising edge of the address byte and at the ninth rising edge of every acknowledged second byte. The request to the converter model is raised after an acquisition delay set in system clock cycles. The chosen channel steps round-robin through the set bits of an enable mask. Results land in a holding register without disturbing the word being shifted out, so each word carries the most recent result that was complete when its first bit was loaded. A STOP puts the block into full shutdown.

Top module: `adc_i2c_reader`

## Requirements
- R1: A START followed by the address DEV_ADDR (default 7'h28) with R/W = 1 is acknowledged: SDA is pulled low for the whole ninth clock, and the shutdown flag drops.
- R2: A different address, or the right address with R/W = 0, is not acknowledged, and SDA stays released until the next START or STOP.
- R3: Every read word is 16 bits, sent as two bytes MSB first. Bits 15:14 are 0, bits 13:12 are the channel number and bits 11:0 are the result. SDA changes only while SCL is low, except when a START or STOP releases it.
- R4: A word carries the last result that was complete when its first bit was loaded (0x0000 after reset). A conversion that finishes mid-word does not change the bits being sent.
- R5: A conversion starts at the ninth SCL rise of the acknowledged address byte. The power-up flag rises, and the conversion request goes high ACQ_CYC cycles later (150 at the 250 MHz / 600 ns defaults). Measured from the SCL change at the pin, this is ACQ_CYC+3 cycles.
- R6: When the controller ACKs a second data byte, a new conversion starts at that ninth rise and another word follows, with no limit on the number of words.
- R7: When the controller NACKs a data byte, no conversion starts, SDA is released, and the power-up flag stays low once the pending conversion is done.
- R8: Successive conversions take the next set bit of chan_en_i above the last channel used, wrapping from 3 to 0. The first conversion after reset takes the lowest set bit. An all-zero mask selects channel 0.
- R9: A STOP sets the shutdown flag and releases SDA. A START in any state releases SDA and begins a fresh address phase, also in the middle of a transfer.
- R10: conv_req_o stays high, with conv_chan_o stable, until conv_valid_i is seen. The result and channel are captured in that cycle.
- R11: pwr_up_o is high from a conversion start until its result is captured. It is low after reset, and conv_req_o is never high while it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_pull_o | output | 1 | 1 = pull SDA low |
| chan_en_i | input | 4 | Channel enable mask, bit n enables channel n |
| conv_req_o | output | 1 | Conversion request to converter |
| conv_chan_o | output | 2 | Channel for the pending conversion |
| conv_valid_i | input | 1 | Converter result valid |
| conv_data_i | input | 12 | Converter result |
| pwr_up_o | output | 1 | Converter powered up / conversion in flight |
| full_shdn_o | output | 1 | Full shutdown state |

## Verification
The checks assume that each SCL phase lasts many system clocks longer than the two-flop synchroniser plus edge detector. They also assume that SDA moves only while SCL is low, apart from START and STOP, and that the converter answers each request exactly once. The bench uses an 80-cycle bit time and changes SDA a quarter bit after each falling edge. Its converter model answers ten cycles after a request. Conversion starts are always at least one byte apart, so a new start never arrives while a conversion is in flight.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_TX,
    ST_MACK,
    ST_NEXT,
    ST_HOLD
  } rd_state_e;

  // Next enabled channel above 'last', wrapping; empty mask gives channel 0.
  function automatic logic [1:0] next_chan(input logic [1:0] last, input logic [3:0] mask);
    logic [1:0] c;
    next_chan = 2'd0;
    for (int i = 4; i >= 1; i--) begin
      c = last + 2'(i);
      if (mask[c]) next_chan = c;
    end
  endfunction

  // Result word: two zero bits, channel id, 12-bit result.
  function automatic logic [15:0] pack_word(input logic [1:0] ch, input logic [11:0] data);
    pack_word = {2'b00, ch, data};
  endfunction

  function automatic logic addr_read_hit(input logic [7:0] rx, input logic [6:0] dev);
    addr_read_hit = (rx == {dev, 1'b1});
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic              scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s    = scl_pipe[STAGES-1];
  assign sda_s    = sda_pipe[STAGES-1];
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/adc_chan_seq.sv
module adc_chan_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step_i,
  input  logic [3:0] mask_i,
  output logic [1:0] chan_o
);
  import adc_rd_pkg::*;

  logic [1:0] last_q;

  assign chan_o = next_chan(last_q, mask_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      last_q <= 2'd3;
    else if (step_i) last_q <= chan_o;
  end
endmodule

// File: rtl/adc_acq_timer.sv
module adc_acq_timer #(
  parameter int ACQ_CYC = 150
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go_i,
  input  logic [1:0] chan_i,
  input  logic       valid_i,
  output logic       busy_o,
  output logic       req_o,
  output logic [1:0] chan_o,
  output logic       done_o
);
  localparam int CNT_W = (ACQ_CYC > 0) ? $clog2(ACQ_CYC + 1) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic [1:0]       chan_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      chan_q <= 2'd0;
    end else if (go_i && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(ACQ_CYC);
      chan_q <= chan_i;
    end else if (busy_q) begin
      if (cnt_q != '0)  cnt_q  <= cnt_q - 1'b1;
      else if (valid_i) busy_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign req_o  = busy_q && (cnt_q == '0);
  assign chan_o = chan_q;
  assign done_o = req_o && valid_i;
endmodule

// File: rtl/adc_i2c_reader.sv
module adc_i2c_reader #(
  parameter logic [6:0] DEV_ADDR    = 7'h28,
  parameter int         CLK_HZ      = 250_000_000,
  parameter int         ACQ_NS      = 600,
  parameter int         SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_pull_o,
  input  logic [3:0]  chan_en_i,
  output logic        conv_req_o,
  output logic [1:0]  conv_chan_o,
  input  logic        conv_valid_i,
  input  logic [11:0] conv_data_i,
  output logic        pwr_up_o,
  output logic        full_shdn_o
);
  import adc_rd_pkg::*;

  localparam int ACQ_CYC = CLK_HZ / 1000 * ACQ_NS / 1_000_000;

  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;

  rd_state_e   st_q;
  logic [3:0]  bitcnt_q;
  logic [7:0]  addr_sh_q;
  logic [15:0] tx_sh_q;
  logic        drive_q, shdn_q, load_q, second_q;
  logic [1:0]  res_ch_q;
  logic [11:0] res_data_q;

  logic [15:0] word_w;
  logic [1:0]  seq_ch_w;
  logic        addr_hit_w, conv_start_w, conv_go_w, mack_nack_w, conv_done_w;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  adc_chan_seq u_seq (
    .clk(clk), .rst_n(rst_n), .step_i(conv_go_w), .mask_i(chan_en_i), .chan_o(seq_ch_w)
  );

  adc_acq_timer #(.ACQ_CYC(ACQ_CYC)) u_acq (
    .clk(clk), .rst_n(rst_n), .go_i(conv_go_w), .chan_i(seq_ch_w),
    .valid_i(conv_valid_i), .busy_o(pwr_up_o), .req_o(conv_req_o),
    .chan_o(conv_chan_o), .done_o(conv_done_w)
  );

  // Named protocol events
  assign word_w       = pack_word(res_ch_q, res_data_q);
  assign addr_hit_w   = (st_q == ST_ADDR) && scl_fall && (bitcnt_q == 4'd8)
                        && addr_read_hit(addr_sh_q, DEV_ADDR);
  assign conv_start_w = scl_rise && ((st_q == ST_AACK)
                        || ((st_q == ST_MACK) && !sda_s && second_q));
  assign conv_go_w    = conv_start_w && !pwr_up_o;
  assign mack_nack_w  = scl_rise && (st_q == ST_MACK) && sda_s;

  // Result holding register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_ch_q   <= 2'd0;
      res_data_q <= 12'd0;
    end else if (conv_done_w) begin
      res_ch_q   <= conv_chan_o;
      res_data_q <= conv_data_i;
    end
  end

  // Bus protocol engine
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      bitcnt_q  <= 4'd0;
      addr_sh_q <= 8'd0;
      tx_sh_q   <= 16'd0;
      drive_q   <= 1'b0;
      shdn_q    <= 1'b1;
      load_q    <= 1'b0;
      second_q  <= 1'b0;
    end else if (stop_ev) begin
      st_q    <= ST_IDLE;
      drive_q <= 1'b0;
      shdn_q  <= 1'b1;
    end else if (start_ev) begin
      st_q     <= ST_ADDR;
      bitcnt_q <= 4'd0;
      drive_q  <= 1'b0;
    end else begin
      case (st_q)
        ST_ADDR: begin
          if (scl_rise) begin
            addr_sh_q <= {addr_sh_q[6:0], sda_s};
            bitcnt_q  <= bitcnt_q + 4'd1;
          end else if (scl_fall && bitcnt_q == 4'd8) begin
            if (addr_hit_w) begin
              st_q    <= ST_AACK;
              drive_q <= 1'b1;
              shdn_q  <= 1'b0;
            end else begin
              st_q <= ST_HOLD;
            end
          end
        end
        ST_AACK: begin
          if (scl_rise) begin
            st_q   <= ST_NEXT;
            load_q <= 1'b1;
          end
        end
        ST_NEXT: begin
          if (scl_fall) begin
            st_q     <= ST_TX;
            bitcnt_q <= 4'd0;
            if (load_q) begin
              drive_q  <= ~word_w[15];
              tx_sh_q  <= {word_w[14:0], 1'b0};
              second_q <= 1'b0;
            end else begin
              drive_q  <= ~tx_sh_q[15];
              tx_sh_q  <= {tx_sh_q[14:0], 1'b0};
              second_q <= 1'b1;
            end
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            bitcnt_q <= bitcnt_q + 4'd1;
          end else if (scl_fall) begin
            if (bitcnt_q == 4'd8) begin
              drive_q <= 1'b0;
              st_q    <= ST_MACK;
            end else begin
              drive_q <= ~tx_sh_q[15];
              tx_sh_q <= {tx_sh_q[14:0], 1'b0};
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            if (!sda_s) begin
              st_q   <= ST_NEXT;
              load_q <= second_q;
            end else begin
              st_q <= ST_HOLD;
            end
          end
        end
        ST_IDLE, ST_HOLD: ;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign sda_pull_o  = drive_q;
  assign full_shdn_o = shdn_q;
endmodule

// File: rtl/adc_i2c_reader_chk.sv
module adc_i2c_reader_chk #(
  parameter int ACQ_CYC = 150
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sda_pull_o,
  input logic       full_shdn_o,
  input logic       pwr_up_o,
  input logic       conv_req_o,
  input logic       conv_valid_i,
  input logic [1:0] conv_chan_o,
  input logic       scl_s,
  input logic       start_ev,
  input logic       stop_ev,
  input logic       conv_go_w,
  input logic       addr_hit_w,
  input logic       mack_nack_w
);
  int unsigned acq_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               acq_cnt <= 0;
    else if (conv_go_w)                       acq_cnt <= 0;
    else if (pwr_up_o && acq_cnt < 32'hFFFF) acq_cnt <= acq_cnt + 1;
  end

  AST_ACK_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    addr_hit_w |=> sda_pull_o && !full_shdn_o); // R1
  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_pull_o) && !$past(start_ev || stop_ev)) |-> !scl_s); // R3
  AST_ACQ_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_req_o) |-> acq_cnt == ACQ_CYC); // R5
  AST_NACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    mack_nack_w |=> !sda_pull_o); // R7
  AST_STOP_SHDN: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> full_shdn_o && !sda_pull_o); // R9
  AST_START_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> !sda_pull_o); // R9
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req_o && !conv_valid_i) |=> conv_req_o); // R10
  AST_CHAN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req_o && !conv_valid_i) |=> $stable(conv_chan_o)); // R10
  AST_PWR_ON_GO: assert property (@(posedge clk) disable iff (!rst_n)
    conv_go_w |=> pwr_up_o); // R11
  AST_REQ_NEEDS_PWR: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req_o |-> pwr_up_o); // R11
endmodule

bind adc_i2c_reader adc_i2c_reader_chk #(.ACQ_CYC(ACQ_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_pull_o(sda_pull_o), .full_shdn_o(full_shdn_o),
  .pwr_up_o(pwr_up_o), .conv_req_o(conv_req_o), .conv_valid_i(conv_valid_i),
  .conv_chan_o(conv_chan_o), .scl_s(scl_s), .start_ev(start_ev), .stop_ev(stop_ev),
  .conv_go_w(conv_go_w), .addr_hit_w(addr_hit_w), .mack_nack_w(mack_nack_w)
);

// File: tb/adc_i2c_reader_tb.sv
`timescale 1ns/1ps
module adc_i2c_reader_tb;
  localparam int QTR = 20;
  localparam int HALF = 40;
  localparam int ACQ = 150;   // 600 ns at 250 MHz
  localparam int LAT = 10;
  localparam logic [6:0] DEV = 7'h28;
  localparam int NVEC = 8;
  // {addr[15:9], rw[8], mask[7:4], words[3:0]}
  localparam logic [15:0] VEC [NVEC] = '{
    {7'h28, 1'b1, 4'b1111, 4'd3},
    {7'h28, 1'b1, 4'b0101, 4'd4},
    {7'h28, 1'b1, 4'b0000, 4'd2},
    {7'h11, 1'b1, 4'b1111, 4'd0},
    {7'h28, 1'b0, 4'b1111, 4'd0},
    {7'h29, 1'b1, 4'b1111, 4'd0},
    {7'h28, 1'b1, 4'b1000, 4'd2},
    {7'h28, 1'b1, 4'b0110, 4'd5}
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, scl_m, sda_m, conv_valid;
  logic [11:0] conv_data;
  logic [3:0] chan_en;
  logic sda_pull, conv_req, pwr_up, shdn;
  logic [1:0] conv_chan;
  logic sda_line;
  assign sda_line = sda_m & ~sda_pull;

  adc_i2c_reader u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .chan_en_i(chan_en), .conv_req_o(conv_req),
    .conv_chan_o(conv_chan), .conv_valid_i(conv_valid), .conv_data_i(conv_data),
    .pwr_up_o(pwr_up), .full_shdn_o(shdn)
  );

  int n_chk = 0, n_bad = 0, cyc = 0, t_conv = 0, cnv_cnt = 0, exp_cnt = 0, last_ch = 3;
  logic [15:0] held = 16'h0000;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int bnext(input int last, input logic [3:0] m);
    if (m == 4'b0000) return 0;
    for (int k = 1; k <= 4; k++) if (m[(last + k) % 4]) return (last + k) % 4;
    return 0;
  endfunction

  // Expected word for a conversion start, then advance the model
  task automatic model_conv(output logic [15:0] w);
    w = held;
    last_ch = bnext(last_ch, chan_en);
    held = {2'b00, 2'(last_ch), 2'(last_ch), 10'(exp_cnt)};
    exp_cnt++;
  endtask

  // Converter model
  initial begin
    conv_valid = 1'b0;
    conv_data = 12'd0;
    forever begin
      @(negedge clk);
      if (conv_req) begin
        chk("R5 request delay", 32'(cyc - t_conv), 32'(ACQ + 3));
        chk("R11 powered while requesting", 32'(pwr_up), 32'd1);
        wt(LAT);
        chk("R10 request held", 32'(conv_req), 32'd1);
        conv_data = {conv_chan, cnv_cnt[9:0]};
        conv_valid = 1'b1;
        @(negedge clk);
        conv_valid = 1'b0;
        cnv_cnt++;
      end
    end
  end

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  task automatic i2c_start();
    sda_m = 1'b1; wt(QTR);
    scl_m = 1'b1; wt(HALF);
    sda_m = 1'b0; wt(HALF);
    scl_m = 1'b0; wt(QTR);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wt(QTR);
    scl_m = 1'b1; wt(HALF);
    sda_m = 1'b1; wt(HALF);
  endtask

  task automatic bit_out(input logic b, input bit mark);
    sda_m = b; wt(QTR);
    scl_m = 1'b1;
    if (mark) t_conv = cyc;
    wt(HALF);
    scl_m = 1'b0; wt(QTR);
  endtask

  task automatic bit_in(output logic v, input bit mark);
    sda_m = 1'b1; wt(QTR);
    scl_m = 1'b1;
    if (mark) t_conv = cyc;
    wt(HALF / 2);
    v = sda_line;
    wt(HALF / 2);
    scl_m = 1'b0; wt(QTR);
  endtask

  task automatic send_addr(input logic [6:0] a, input logic rw, input bit expect_ack);
    logic [7:0] b;
    logic v;
    b = {a, rw};
    for (int i = 7; i >= 0; i--) bit_out(b[i], 1'b0);
    bit_in(v, expect_ack);
    chk(expect_ack ? "R1 address acknowledged" : "R2 address ignored",
        32'(v), expect_ack ? 32'd0 : 32'd1);
  endtask

  task automatic read_word(output logic [15:0] got, input logic last_ack);
    logic v;
    got = 16'h0;
    for (int i = 0; i < 8; i++) begin bit_in(v, 1'b0); got = {got[14:0], v}; end
    bit_out(1'b0, 1'b0);
    for (int i = 0; i < 8; i++) begin bit_in(v, 1'b0); got = {got[14:0], v}; end
    bit_out(last_ack, !last_ack);
  endtask

  task automatic do_reads(input int n);
    logic [15:0] exp, got;
    model_conv(exp);
    for (int w = 0; w < n; w++) begin
      read_word(got, (w == n - 1));
      chk("R3 R4 R8 word content", 32'(got), 32'(exp));
      if (w < n - 1) model_conv(exp);
    end
  endtask

  task automatic after_stop();
    wt(300);
    chk("R9 shutdown after stop", 32'(shdn), 32'd1);
    chk("R9 SDA released after stop", 32'(sda_pull), 32'd0);
    chk("R7 powered down after NACK", 32'(pwr_up), 32'd0);
    chk("R6 R7 conversion count", 32'(cnv_cnt), 32'(exp_cnt));
  endtask

  initial begin
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; chan_en = 4'hF;
    wt(5);
    rst_n = 1'b1;
    wt(3);
    chk("R9 reset shutdown", 32'(shdn), 32'd1);
    chk("R9 reset SDA released", 32'(sda_pull), 32'd0);
    chk("R11 reset powered down", 32'(pwr_up), 32'd0);
    chk("R10 reset no request", 32'(conv_req), 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      logic [6:0] a;
      logic rw;
      logic [3:0] nw;
      logic acked;
      logic [15:0] got;
      logic v;
      a = VEC[i][15:9]; rw = VEC[i][8]; chan_en = VEC[i][7:4]; nw = VEC[i][3:0];
      acked = (a == DEV) && rw;
      wt(20);
      i2c_start();
      send_addr(a, rw, acked);
      if (acked) begin
        chk("R1 shutdown cleared", 32'(shdn), 32'd0);
        do_reads(int'(nw));
      end else begin
        got = 16'h0;
        for (int b = 0; b < 16; b++) begin bit_in(v, 1'b0); got = {got[14:0], v}; end
        chk("R2 bus stays released", 32'(got), 32'hFFFF);
      end
      i2c_stop();
      after_stop();
    end

    // R9: START in the middle of an address byte restarts address reception
    chan_en = 4'b1011;
    wt(20);
    i2c_start();
    bit_out(1'b0, 1'b0); bit_out(1'b1, 1'b0); bit_out(1'b0, 1'b0);
    i2c_start();
    send_addr(DEV, 1'b1, 1'b1);
    do_reads(1);
    // R9: repeated START after a NACK, no STOP in between
    i2c_start();
    chk("R9 shutdown held without stop", 32'(shdn), 32'd0);
    send_addr(DEV, 1'b1, 1'b1);
    do_reads(3);
    i2c_stop();
    after_stop();

    finish_run();
  end
endmodule